// File: doc/BRIEF.md
# Power-up self-test flash sequencer

This block orders the power-up self-tests of a module built from two sections that share one status LED. Each section owns a fixed list of test engines. The sequencer starts them one at a time and waits for each result. For every test that passes, it blinks the LED once. The first section begins right after reset. The second section waits out a holdoff, and from then on the LED shows only that section.

On the first failing test, a section freezes where it is. It starts no further test and keeps the LED steady. An operator counts the blinks to find the broken circuit. A section lights the LED from its start until its first test passes. So a section that is dead from the outset holds the LED on. If both sections are dead, the LED comes on after reset and never goes off.

Flash on-time, flash off-time and holdoff are parameters in clock cycles. The default holdoff is a long one, and the bench shortens it.

Top module: `selftest_flash_seq`

## Requirements
- R1: While reset is asserted, led_o, ready_o, halted_o, a_ok_o and every start line are 0, and cur_test_o is 0.
- R2: Each start line is a one-hot, one-cycle pulse. A section starts its tests in index order, and it starts a test only after the flash of the previous test has ended.
- R3: A test counts when its done bit and pass bit are both 1. It then produces exactly FLASH_OFF cycles of LED low, followed by exactly FLASH_ON cycles of LED high.
- R4: A test fails when its done bit is 1 and its pass bit is 0. The section then starts no further test, and halted_o rises and stays high until reset. ready_o is never 1 while halted_o is 1.
- R5: The first section starts test 0 right after reset. The second section issues no start before HOLDOFF cycles after reset, and it issues its first start within two cycles after that.
- R6: A section drives the LED high from its first start until its first pass. If its first test fails, the LED stays high.
- R7: Once the second section has started, led_o follows only the second section. Any flash of the first section still in progress is cut off.
- R8: ready_o is 1 exactly when all N_A + N_B tests have passed, and cur_test_o then equals N_A + N_B.
- R9: cur_test_o gives the global index of the test that is running or has halted. The index counts the first section from 0 and the second section from N_A. A halted first section takes priority.
- R10: a_ok_o rises once every test of the first section has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_start_o | output | N_A | Start pulses to the first-section engines |
| a_done_i | input | N_A | Done flags from the first-section engines |
| a_pass_i | input | N_A | Pass flags from the first-section engines, valid with done |
| b_start_o | output | N_B | Start pulses to the second-section engines |
| b_done_i | input | N_B | Done flags from the second-section engines |
| b_pass_i | input | N_B | Pass flags from the second-section engines, valid with done |
| led_o | output | 1 | Shared status LED |
| cur_test_o | output | IDX_W | Global index of the current or halted test |
| a_ok_o | output | 1 | First section completed with all tests passing |
| halted_o | output | 1 | A section has stopped on a failure |
| ready_o | output | 1 | All tests of both sections passed |

## Verification
Two events can land in the same cycle: the expiry of the holdoff and a flash of the first section that is still running. The bench provokes this by stretching the first-section test latency so that its second flash straddles the cycle in which the second section starts. The blinks are then counted as runs of exactly FLASH_ON high cycles. The second flash merges into the lamp of the second section and must not count, so the bench expects eight blinks, with a_ok_o and ready_o still set. The other scenarios place failures at chosen indices and compare the blink count, cur_test_o and the steady LED level against the requirements.

// File: rtl/selftest_flash_pkg.sv
package selftest_flash_pkg;
  typedef enum logic [2:0] {
    SQ_WAIT,
    SQ_RUN,
    SQ_GAP,
    SQ_PULSE,
    SQ_DONE,
    SQ_HALT
  } sq_state_e;
endpackage

// File: rtl/selftest_holdoff.sv
module selftest_holdoff #(
  parameter int unsigned HOLDOFF = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic go_o
);
  localparam int unsigned CW = $clog2(HOLDOFF + 1);

  logic [CW-1:0] cnt_q;
  logic          go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      go_q  <= 1'b0;
    end else if (!go_q) begin
      if (cnt_q == CW'(HOLDOFF - 1)) go_q <= 1'b1;
      else                           cnt_q <= cnt_q + 1'b1;
    end
  end

  assign go_o = go_q;
endmodule

// File: rtl/selftest_section.sv
module selftest_section
  import selftest_flash_pkg::*;
#(
  parameter int unsigned N_TESTS   = 2,
  parameter int unsigned FLASH_ON  = 4,
  parameter int unsigned FLASH_OFF = 4,
  parameter int unsigned IDX_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [N_TESTS-1:0] done_i,
  input  logic [N_TESTS-1:0] pass_i,
  output logic [N_TESTS-1:0] start_o,
  output logic               led_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               active_o,
  output logic               ok_o,
  output logic               halt_o
);
  localparam int unsigned TMAX = (FLASH_ON > FLASH_OFF) ? FLASH_ON : FLASH_OFF;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  sq_state_e          st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CW-1:0]      cnt_q;
  logic [N_TESTS-1:0] start_q;
  logic               seen_q;   // at least one pass: lamp released

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_WAIT;
      idx_q   <= '0;
      cnt_q   <= '0;
      start_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      start_q <= '0;
      unique case (st_q)
        SQ_WAIT: begin
          if (go_i) begin
            st_q    <= SQ_RUN;
            start_q <= N_TESTS'(1);
          end
        end
        SQ_RUN: begin
          if (done_i[idx_q]) begin
            if (pass_i[idx_q]) begin
              seen_q <= 1'b1;
              st_q   <= SQ_GAP;
              cnt_q  <= CW'(FLASH_OFF - 1);
            end else begin
              st_q <= SQ_HALT;
            end
          end
        end
        SQ_GAP: begin
          if (cnt_q == '0) begin
            st_q  <= SQ_PULSE;
            cnt_q <= CW'(FLASH_ON - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_PULSE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (idx_q == IDX_W'(N_TESTS - 1)) begin
            st_q <= SQ_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            st_q    <= SQ_RUN;
            start_q <= N_TESTS'(1) << (idx_q + 1'b1);
          end
        end
        SQ_DONE: ;
        SQ_HALT: ;
        default: st_q <= SQ_HALT;
      endcase
    end
  end

  assign start_o  = start_q;
  assign led_o    = (st_q == SQ_PULSE) |
                    (!seen_q && (st_q == SQ_RUN || st_q == SQ_HALT));
  assign idx_o    = (st_q == SQ_DONE) ? IDX_W'(N_TESTS) : idx_q;
  assign active_o = (st_q != SQ_WAIT);
  assign ok_o     = (st_q == SQ_DONE);
  assign halt_o   = (st_q == SQ_HALT);
endmodule

// File: rtl/selftest_flash_seq.sv
module selftest_flash_seq #(
  parameter int unsigned N_A       = 2,
  parameter int unsigned N_B       = 7,
  parameter int unsigned FLASH_ON  = 12_500_000,
  parameter int unsigned FLASH_OFF = 12_500_000,
  parameter int unsigned HOLDOFF   = 1_500_000_000,
  parameter int unsigned IDX_W     = $clog2(N_A + N_B + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [N_A-1:0]   a_start_o,
  input  logic [N_A-1:0]   a_done_i,
  input  logic [N_A-1:0]   a_pass_i,
  output logic [N_B-1:0]   b_start_o,
  input  logic [N_B-1:0]   b_done_i,
  input  logic [N_B-1:0]   b_pass_i,
  output logic             led_o,
  output logic [IDX_W-1:0] cur_test_o,
  output logic             a_ok_o,
  output logic             halted_o,
  output logic             ready_o
);
  logic             b_go;
  logic             a_led, b_led, a_act, b_act, a_ok, b_ok, a_halt, b_halt;
  logic [IDX_W-1:0] a_idx, b_idx;

  selftest_holdoff #(.HOLDOFF(HOLDOFF)) u_holdoff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_o  (b_go)
  );

  selftest_section #(
    .N_TESTS(N_A), .FLASH_ON(FLASH_ON), .FLASH_OFF(FLASH_OFF), .IDX_W(IDX_W)
  ) u_sec_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (1'b1),
    .done_i  (a_done_i),
    .pass_i  (a_pass_i),
    .start_o (a_start_o),
    .led_o   (a_led),
    .idx_o   (a_idx),
    .active_o(a_act),
    .ok_o    (a_ok),
    .halt_o  (a_halt)
  );

  selftest_section #(
    .N_TESTS(N_B), .FLASH_ON(FLASH_ON), .FLASH_OFF(FLASH_OFF), .IDX_W(IDX_W)
  ) u_sec_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (b_go),
    .done_i  (b_done_i),
    .pass_i  (b_pass_i),
    .start_o (b_start_o),
    .led_o   (b_led),
    .idx_o   (b_idx),
    .active_o(b_act),
    .ok_o    (b_ok),
    .halt_o  (b_halt)
  );

  // second section owns the LED once it has started
  assign led_o      = b_act ? b_led : (a_led & a_act);
  assign cur_test_o = (a_halt || !b_act) ? a_idx : (IDX_W'(N_A) + b_idx);
  assign a_ok_o     = a_ok;
  assign halted_o   = a_halt | b_halt;
  assign ready_o    = a_ok & b_ok;
endmodule

// File: rtl/selftest_flash_seq_chk.sv
module selftest_flash_seq_chk #(
  parameter int unsigned N_A       = 2,
  parameter int unsigned N_B       = 7,
  parameter int unsigned FLASH_ON  = 4,
  parameter int unsigned FLASH_OFF = 4,
  parameter int unsigned HOLDOFF   = 16,
  parameter int unsigned IDX_W     = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_A-1:0]   a_start_o,
  input logic [N_B-1:0]   b_start_o,
  input logic             led_o,
  input logic [IDX_W-1:0] cur_test_o,
  input logic             a_ok_o,
  input logic             halted_o,
  input logic             ready_o
);
  localparam int unsigned CW = $clog2(HOLDOFF + 2);
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cyc_q <= '0;
    else if (cyc_q != CW'(HOLDOFF))  cyc_q <= cyc_q + 1'b1;
  end

  assert_start_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(a_start_o) && $onehot0(b_start_o));
  assert_start_single_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_start_o != '0) |=> (a_start_o == '0));
  assert_start_single_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_start_o != '0) |=> (b_start_o == '0));
  assert_halt_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  assert_no_ready_on_halt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !ready_o);
  assert_b_holdoff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < CW'(HOLDOFF)) |-> (b_start_o == '0));
  assert_ready_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  assert_ready_index_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cur_test_o == IDX_W'(N_A + N_B)));
  assert_a_ok_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_ok_o |=> a_ok_o);
endmodule

bind selftest_flash_seq selftest_flash_seq_chk #(
  .N_A(N_A), .N_B(N_B), .FLASH_ON(FLASH_ON), .FLASH_OFF(FLASH_OFF),
  .HOLDOFF(HOLDOFF), .IDX_W(IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_start_o (a_start_o),
  .b_start_o (b_start_o),
  .led_o     (led_o),
  .cur_test_o(cur_test_o),
  .a_ok_o    (a_ok_o),
  .halted_o  (halted_o),
  .ready_o   (ready_o)
);

// File: tb/selftest_flash_seq_bench.sv
`timescale 1ns/1ps
module selftest_flash_seq_bench;
  localparam int N_A = 2, N_B = 7, ON = 3, OFF = 2, HOLD = 120;
  localparam int IDX_W = $clog2(N_A + N_B + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N_A-1:0] a_start, a_done = '0, a_pass = '0;
  logic [N_B-1:0] b_start, b_done = '0, b_pass = '0;
  logic led, a_ok, halted, ready;
  logic [IDX_W-1:0] cur;

  selftest_flash_seq #(.N_A(N_A), .N_B(N_B), .FLASH_ON(ON), .FLASH_OFF(OFF),
                       .HOLDOFF(HOLD)) u_selftest_flash_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .a_start_o(a_start), .a_done_i(a_done), .a_pass_i(a_pass),
    .b_start_o(b_start), .b_done_i(b_done), .b_pass_i(b_pass),
    .led_o(led), .cur_test_o(cur), .a_ok_o(a_ok), .halted_o(halted), .ready_o(ready));

  int checks = 0, fails = 0;
  int a_fail = 99, b_fail = 99, a_lat = 6, b_lat = 6;
  int cyc = 0, run = 0, pulses = 0, b_first = -1, a_starts = 0, b_starts = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: cycle count, blink count (runs of exactly ON high cycles), starts
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; run = 0; pulses = 0; b_first = -1; a_starts = 0; b_starts = 0;
    end else begin
      cyc++;
      if (led) run++;
      else begin
        if (run == ON) pulses++;
        run = 0;
      end
      if (a_start != 0) a_starts++;
      if (b_start != 0) begin
        b_starts++;
        if (b_first < 0) b_first = cyc;
      end
    end
  end

  // stub engines
  initial forever begin
    @(negedge clk);
    if (rst_n && a_start != 0) begin
      int k = 0;
      for (int i = 0; i < N_A; i++) if (a_start[i]) k = i;
      repeat (a_lat - 1) @(negedge clk);
      a_done[k] = 1'b1; a_pass[k] = (k != a_fail);
      @(negedge clk);
      a_done = '0; a_pass = '0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (rst_n && b_start != 0) begin
      int k = 0;
      for (int i = 0; i < N_B; i++) if (b_start[i]) k = i;
      repeat (b_lat - 1) @(negedge clk);
      b_done[k] = 1'b1; b_pass[k] = (k != b_fail);
      @(negedge clk);
      b_done = '0; b_pass = '0;
    end
  end

  task automatic start_run(input int af, input int bf, input int al);
    rst_n = 1'b0;
    a_fail = af; b_fail = bf; a_lat = al; b_lat = 6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(led == 0 && ready == 0 && halted == 0 && a_ok == 0, "R1 outputs", {led, ready, halted, a_ok}, 0);
    chk(a_start == 0 && b_start == 0 && cur == 0, "R1 starts/index", int'(cur), 0);
  endtask

  task automatic t_all_pass();
    start_run(99, 99, 6);
    repeat (2) @(negedge clk);
    chk(led == 1, "R6 lamp after reset", led, 1);
    repeat (400) @(negedge clk);
    chk(pulses == 9, "R3 blinks all pass", pulses, 9);
    chk(ready == 1 && halted == 0, "R8 ready", ready, 1);
    chk(cur == N_A + N_B, "R8 final index", cur, N_A + N_B);
    chk(a_ok == 1, "R10 first section ok", a_ok, 1);
    chk(b_first >= HOLD && b_first <= HOLD + 2, "R5 holdoff", b_first, HOLD + 1);
    chk(a_starts == N_A && b_starts == N_B, "R2 start count", a_starts + b_starts, N_A + N_B);
  endtask

  task automatic t_a_fail1();
    start_run(1, 99, 6);
    repeat (100) @(negedge clk);
    chk(halted == 1 && a_ok == 0, "R4 first section halt", halted, 1);
    chk(a_starts == 2, "R4 no start after fail", a_starts, 2);
    chk(led == 0, "R4 steady off after pass", led, 0);
    repeat (300) @(negedge clk);
    chk(pulses == 1 + N_B, "R7 blinks A fail at 1", pulses, 1 + N_B);
    chk(ready == 0, "R4 no ready", ready, 0);
    chk(cur == 1, "R9 index A priority", cur, 1);
  endtask

  task automatic t_b_fail3();
    start_run(99, 3, 6);
    repeat (400) @(negedge clk);
    chk(pulses == N_A + 3, "R3 blinks B fail at 3", pulses, N_A + 3);
    chk(halted == 1 && ready == 0 && a_ok == 1, "R4 B halt", {halted, ready, a_ok}, 3'b101);
    chk(cur == N_A + 3, "R9 index B fail", cur, N_A + 3);
    chk(b_starts == 4, "R4 B no more starts", b_starts, 4);
  endtask

  task automatic t_both_dead();
    start_run(0, 0, 6);
    repeat (60) @(negedge clk);
    chk(led == 1, "R6 lamp both dead mid", led, 1);
    repeat (340) @(negedge clk);
    chk(led == 1 && pulses == 0, "R6 lamp both dead end", pulses, 0);
    chk(run > 350, "R6 LED never dropped", run, 350);
    chk(cur == 0 && halted == 1, "R9 index both dead", cur, 0);
  endtask

  task automatic t_a_dead();
    start_run(0, 99, 6);
    repeat (60) @(negedge clk);
    chk(led == 1, "R6 lamp during holdoff", led, 1);
    repeat (340) @(negedge clk);
    chk(pulses == N_B, "R7 B blinks after dead A", pulses, N_B);
    chk(ready == 0 && halted == 1, "R4 no ready A dead", ready, 0);
  endtask

  task automatic t_overlap();
    start_run(99, 99, 56);
    repeat (450) @(negedge clk);
    chk(pulses == 1 + N_B, "R7 A flash cut by B start", pulses, 1 + N_B);
    chk(a_ok == 1 && ready == 1, "R10 A ok despite cut", {a_ok, ready}, 3);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_all_pass();
    t_a_fail1();
    t_b_fail3();
    t_both_dead();
    t_a_dead();
    t_overlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule